// File: doc/BRIEF.md
# Power-Loss Resume State Controller

This block lives in the battery-backed, always-on domain and decides what the platform does when main power comes back after a mechanical-off outage. It holds two bits in one 8-bit register. The first is a sticky flag that records a failure of the backup supply. The second is a resume-select bit that picks between booting straight to the working state and staying off.

When the power-return strobe arrives, the block combines the resume-select bit with the sleep state recorded before the outage. It then produces a registered target state. If resume-select is set and the platform was in hibernate before the outage, the target is hibernate; otherwise the target is soft-off. If resume-select is clear, the target is always the working state.

Hardware can change the resume-select bit without software. A thermal-trip shutdown forces it to 1, and a write strobe on the reset-control port clears it. The raw always-on reset passes through a two-flop synchronizer before it reaches any state. Its assertion acts at once and its release is synchronous to the always-on clock.

Top module: `pwrloss_resume_ctrl`

## Requirements
- R1: While the synchronized always-on reset is active, the register reads 0x00, `target_o` reads 2'b00 and `target_vld_o` reads 0.
- R2: A high `supply_fail_i` at a clock edge makes register bit 1 (the power-fail flag) read 1 after that edge. The flag then stays at 1 until it is cleared.
- R3: A register write with bit 1 of the write data set clears the power-fail flag. A register write with that bit at 0 leaves the flag unchanged.
- R4: If `supply_fail_i` is high in the same cycle as a write-1-to-clear of the flag, the flag ends up at 1.
- R5: Register bit 0 (resume-select) takes bit 0 of the write data on a register write. Bits 7:2 always read 0, whatever is written to them.
- R6: A high `thermal_trip_i` sets resume-select to 1. This takes priority over a reset-control write and over a register write in the same cycle.
- R7: A pulse on `rstctl_wr_i` clears resume-select, and takes priority over a register write in the same cycle. It has no effect on the power-fail flag.
- R8: When `pwr_return_i` is high at an edge, after that edge `target_vld_o` is 1 for one cycle and `target_o` shows the target for the resume-select value held before that edge. The target is 2'b00 (working) when resume-select is 0. When resume-select is 1, it is 2'b10 (hibernate) if `last_state_i` equals 2'b10, and 2'b01 (soft-off) for any other value.
- R9: `target_o` holds its value in every cycle that has no power-return strobe.
- R10: The release of `rst_aon_n` takes effect after two clock edges: the first clock edge at which a state register can change is the third edge after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Slow always-on clock |
| rst_aon_n | input | 1 | Raw always-on domain reset, active low |
| supply_fail_i | input | 1 | Backup supply failure indication |
| thermal_trip_i | input | 1 | Thermal-trip shutdown event |
| rstctl_wr_i | input | 1 | Write strobe to the reset-control port |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| last_state_i | input | 2 | Sleep state recorded before the outage (00 working, 01 soft-off, 10 hibernate) |
| pwr_return_i | input | 1 | Main power has returned (one-cycle strobe) |
| target_o | output | 2 | Resume target state (00 working, 01 soft-off, 10 hibernate) |
| target_vld_o | output | 1 | Target valid, one cycle after the strobe |

## Verification
The directed cases aim at same-cycle collisions.

A supply failure that coincides with a clear must leave the flag at 1. A design with the priority reversed would lose a real battery failure.

A thermal trip that coincides with a reset-control write or a register write must leave resume-select set. A design that lets the clear win would boot straight into an overheated platform.

The hibernate exception is checked with resume-select both set and clear. A design that ignores resume-select, or that matches `last_state_i` loosely, would resume into hibernate or soft-off when it should not.

Reset release is checked cycle by cycle. A design that skips the synchronizer would latch the supply-fail flag two edges early.

// File: rtl/pwrloss_pkg.sv
package pwrloss_pkg;
  typedef enum logic [1:0] {
    ST_WORK    = 2'b00,
    ST_SOFTOFF = 2'b01,
    ST_HIBER   = 2'b10
  } pwr_state_e;

  localparam int unsigned REG_W    = 8;
  localparam int unsigned FLAG_BIT = 1;
  localparam int unsigned SEL_BIT  = 0;
endpackage

// File: rtl/aon_rst_sync.sv
module aon_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_raw_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_raw_n) begin
        if (!rst_raw_n) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= 1'b1;
        else             chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pwrloss_sticky_bits.sv
module pwrloss_sticky_bits
  import pwrloss_pkg::*;
#(
  parameter int unsigned DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_fail_i,
  input  logic              thermal_trip_i,
  input  logic              rstctl_wr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_q_o
);
  localparam logic [DATA_W-1:0] W1C_MASK  = DATA_W'(1) << FLAG_BIT;
  localparam logic [DATA_W-1:0] RW_MASK   = DATA_W'(1) << SEL_BIT;
  localparam logic [DATA_W-1:0] IMPL_MASK = W1C_MASK | RW_MASK;

  logic [DATA_W-1:0] reg_q, reg_d, wr_merge;

  // Next-state: software write merge, then hardware overrides by priority.
  always_comb begin
    wr_merge = (reg_q & ~IMPL_MASK)
             | (reg_wdata_i & RW_MASK)
             | (reg_q & ~reg_wdata_i & W1C_MASK);
    reg_d = reg_wr_i ? wr_merge : reg_q;
    if (rstctl_wr_i)    reg_d[SEL_BIT]  = 1'b0;
    if (thermal_trip_i) reg_d[SEL_BIT]  = 1'b1;
    if (supply_fail_i)  reg_d[FLAG_BIT] = 1'b1;
    reg_d = reg_d & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= '0;
    else        reg_q <= reg_d;
  end

  assign reg_q_o = reg_q;
endmodule

// File: rtl/pwrloss_resume_dec.sv
module pwrloss_resume_dec
  import pwrloss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_return_i,
  input  logic       sel_i,
  input  logic [1:0] last_state_i,
  output logic [1:0] target_o,
  output logic       target_vld_o
);
  pwr_state_e tgt_q, tgt_d, resolved;
  logic       vld_q;

  always_comb begin
    if (!sel_i)                    resolved = ST_WORK;
    else if (last_state_i == ST_HIBER) resolved = ST_HIBER;
    else                           resolved = ST_SOFTOFF;
    tgt_d = pwr_return_i ? resolved : tgt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= ST_WORK;
      vld_q <= 1'b0;
    end else begin
      tgt_q <= tgt_d;
      vld_q <= pwr_return_i;
    end
  end

  assign target_o     = tgt_q;
  assign target_vld_o = vld_q;
endmodule

// File: rtl/pwrloss_resume_ctrl.sv
module pwrloss_resume_ctrl
  import pwrloss_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_aon,
  input  logic             rst_aon_n,
  input  logic             supply_fail_i,
  input  logic             thermal_trip_i,
  input  logic             rstctl_wr_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic [1:0]       last_state_i,
  input  logic             pwr_return_i,
  output logic [1:0]       target_o,
  output logic             target_vld_o
);
  logic             rst_n_sync;
  logic [REG_W-1:0] reg_q;

  aon_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk_aon),
    .rst_raw_n  (rst_aon_n),
    .rst_sync_n (rst_n_sync)
  );

  pwrloss_sticky_bits #(.DATA_W(REG_W)) u_bits (
    .clk            (clk_aon),
    .rst_n          (rst_n_sync),
    .supply_fail_i  (supply_fail_i),
    .thermal_trip_i (thermal_trip_i),
    .rstctl_wr_i    (rstctl_wr_i),
    .reg_wr_i       (reg_wr_i),
    .reg_wdata_i    (reg_wdata_i),
    .reg_q_o        (reg_q)
  );

  pwrloss_resume_dec u_dec (
    .clk          (clk_aon),
    .rst_n        (rst_n_sync),
    .pwr_return_i (pwr_return_i),
    .sel_i        (reg_q[SEL_BIT]),
    .last_state_i (last_state_i),
    .target_o     (target_o),
    .target_vld_o (target_vld_o)
  );

  assign reg_rdata_o = reg_q;
endmodule

// File: rtl/pwrloss_resume_ctrl_chk.sv
module pwrloss_resume_ctrl_chk
  import pwrloss_pkg::*;
(
  input logic             clk_aon,
  input logic             rst_n_sync,
  input logic             supply_fail_i,
  input logic             thermal_trip_i,
  input logic             rstctl_wr_i,
  input logic             reg_wr_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic [1:0]       last_state_i,
  input logic             pwr_return_i,
  input logic [1:0]       target_o,
  input logic             target_vld_o
);
  a_r2_fail_sets: assert property (@(posedge clk_aon) disable iff (!rst_n_sync)
    supply_fail_i |=> reg_rdata_o[FLAG_BIT]);

  a_r3_w1c_clears: assert property (@(posedge clk_aon) disable iff (!rst_n_sync)
    (reg_wr_i && reg_wdata_i[FLAG_BIT] && !supply_fail_i) |=> !reg_rdata_o[FLAG_BIT]);

  a_r3_flag_sticky: assert property (@(posedge clk_aon) disable iff (!rst_n_sync)
    (!supply_fail_i && !(reg_wr_i && reg_wdata_i[FLAG_BIT])) |=> $stable(reg_rdata_o[FLAG_BIT]));

  a_r5_sel_write: assert property (@(posedge clk_aon) disable iff (!rst_n_sync)
    (reg_wr_i && !thermal_trip_i && !rstctl_wr_i) |=> (reg_rdata_o[SEL_BIT] == $past(reg_wdata_i[SEL_BIT])));

  a_r6_thermal_sets: assert property (@(posedge clk_aon) disable iff (!rst_n_sync)
    thermal_trip_i |=> reg_rdata_o[SEL_BIT]);

  a_r7_rstctl_clears: assert property (@(posedge clk_aon) disable iff (!rst_n_sync)
    (rstctl_wr_i && !thermal_trip_i) |=> !reg_rdata_o[SEL_BIT]);

  a_r8_work_target: assert property (@(posedge clk_aon) disable iff (!rst_n_sync)
    (pwr_return_i && !reg_rdata_o[SEL_BIT]) |=> (target_vld_o && target_o == ST_WORK));

  a_r8_hiber_target: assert property (@(posedge clk_aon) disable iff (!rst_n_sync)
    (pwr_return_i && reg_rdata_o[SEL_BIT] && last_state_i == ST_HIBER) |=> (target_o == ST_HIBER));

  a_r9_target_hold: assert property (@(posedge clk_aon) disable iff (!rst_n_sync)
    !pwr_return_i |=> ($stable(target_o) && !target_vld_o));
endmodule

bind pwrloss_resume_ctrl pwrloss_resume_ctrl_chk u_chk (
  .clk_aon        (clk_aon),
  .rst_n_sync     (rst_n_sync),
  .supply_fail_i  (supply_fail_i),
  .thermal_trip_i (thermal_trip_i),
  .rstctl_wr_i    (rstctl_wr_i),
  .reg_wr_i       (reg_wr_i),
  .reg_wdata_i    (reg_wdata_i),
  .reg_rdata_o    (reg_rdata_o),
  .last_state_i   (last_state_i),
  .pwr_return_i   (pwr_return_i),
  .target_o       (target_o),
  .target_vld_o   (target_vld_o)
);

// File: tb/pwrloss_resume_ctrl_tb.sv
`timescale 1ns/1ps
module pwrloss_resume_ctrl_tb;
  logic       clk_aon = 1'b0;
  logic       rst_aon_n;
  logic       supply_fail_i, thermal_trip_i, rstctl_wr_i, reg_wr_i, pwr_return_i;
  logic [7:0] reg_wdata_i, reg_rdata_o;
  logic [1:0] last_state_i, target_o;
  logic       target_vld_o;

  int checks = 0;
  int failures = 0;

  // bench model
  logic       m_flag, m_sel, m_vld;
  logic [1:0] m_tgt;

  always #10 clk_aon = ~clk_aon;

  pwrloss_resume_ctrl u_dut (
    .clk_aon(clk_aon), .rst_aon_n(rst_aon_n),
    .supply_fail_i(supply_fail_i), .thermal_trip_i(thermal_trip_i),
    .rstctl_wr_i(rstctl_wr_i), .reg_wr_i(reg_wr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .last_state_i(last_state_i), .pwr_return_i(pwr_return_i),
    .target_o(target_o), .target_vld_o(target_vld_o)
  );

  function automatic logic [1:0] exp_target(input logic sel, input logic [1:0] last);
    if (!sel)              return 2'b00;
    else if (last == 2'b10) return 2'b10;
    else                   return 2'b01;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    supply_fail_i = 0; thermal_trip_i = 0; rstctl_wr_i = 0;
    reg_wr_i = 0; reg_wdata_i = 8'h00; pwr_return_i = 0;
  endtask

  // Apply current inputs for one edge; update model; sample at next negedge.
  task automatic step();
    logic nf, ns;
    nf = supply_fail_i ? 1'b1 : (reg_wr_i && reg_wdata_i[1]) ? 1'b0 : m_flag;
    ns = thermal_trip_i ? 1'b1 : rstctl_wr_i ? 1'b0 : reg_wr_i ? reg_wdata_i[0] : m_sel;
    if (pwr_return_i) m_tgt = exp_target(m_sel, last_state_i);
    m_vld  = pwr_return_i;
    m_flag = nf;
    m_sel  = ns;
    @(negedge clk_aon);
  endtask

  task automatic cmp_all(input string req);
    check(req, {8'h00, reg_rdata_o}, {8'h00, 6'b0, m_flag, m_sel});
    check(req, {13'h0, target_vld_o, target_o}, {13'h0, m_vld, m_tgt});
  endtask

  task automatic do_reset();
    idle();
    rst_aon_n = 0;
    repeat (3) @(negedge clk_aon);
    m_flag = 0; m_sel = 0; m_vld = 0; m_tgt = 2'b00;
  endtask

  initial begin : watchdog
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    last_state_i = 2'b00;
    do_reset();
    // R1: reset state
    check("R1 reset regs", {8'h00, reg_rdata_o}, 16'h0000);
    check("R1 reset target", {13'h0, target_vld_o, target_o}, 16'h0000);

    // R10: synchronized release; supply_fail held across release
    supply_fail_i = 1;
    rst_aon_n = 1;
    @(negedge clk_aon);
    check("R10 edge1", {8'h00, reg_rdata_o}, 16'h0000);
    @(negedge clk_aon);
    check("R10 edge2", {8'h00, reg_rdata_o}, 16'h0000);
    @(negedge clk_aon);
    check("R10 edge3 flag", {8'h00, reg_rdata_o}, 16'h0002);
    m_flag = 1;

    // R2: sticky after fail drops
    idle(); step(); step();
    check("R2 flag sticky", {8'h00, reg_rdata_o}, 16'h0002);
    // R3: write 0 no effect
    reg_wr_i = 1; reg_wdata_i = 8'h00; step(); idle();
    check("R3 write0 keeps flag", {15'h0, reg_rdata_o[1]}, 16'h0001);
    // R4: set wins over clear
    reg_wr_i = 1; reg_wdata_i = 8'h02; supply_fail_i = 1; step(); idle();
    check("R4 set beats w1c", {15'h0, reg_rdata_o[1]}, 16'h0001);
    // R3: W1C clears
    reg_wr_i = 1; reg_wdata_i = 8'h02; step(); idle();
    check("R3 w1c clears", {15'h0, reg_rdata_o[1]}, 16'h0000);
    // R5: sel write, reserved bits read 0
    reg_wr_i = 1; reg_wdata_i = 8'hFD; step(); idle();
    check("R5 sel write reserved zero", {8'h00, reg_rdata_o}, 16'h0001);
    // R7: rstctl clear beats reg write, flag untouched
    supply_fail_i = 1; step(); idle();
    rstctl_wr_i = 1; reg_wr_i = 1; reg_wdata_i = 8'h01; step(); idle();
    check("R7 rstctl clears sel keeps flag", {8'h00, reg_rdata_o}, 16'h0002);
    // R6: thermal beats rstctl and reg write
    thermal_trip_i = 1; rstctl_wr_i = 1; reg_wr_i = 1; reg_wdata_i = 8'h00; step(); idle();
    check("R6 thermal wins", {15'h0, reg_rdata_o[0]}, 16'h0001);
    // R8: hibernate exception and soft-off
    last_state_i = 2'b10; pwr_return_i = 1; step(); idle();
    check("R8 hiber target", {13'h0, target_vld_o, target_o}, 16'h0006);
    step();
    check("R9 hold no strobe", {13'h0, target_vld_o, target_o}, 16'h0002);
    last_state_i = 2'b11; pwr_return_i = 1; step(); idle();
    check("R8 softoff target", {13'h0, target_vld_o, target_o}, 16'h0005);
    // R8: sel clear with hibernate last state -> working
    rstctl_wr_i = 1; step(); idle();
    last_state_i = 2'b10; pwr_return_i = 1; step(); idle();
    check("R8 work target despite hiber", {13'h0, target_vld_o, target_o}, 16'h0004);

    // Random mix (R2..R9)
    for (int i = 0; i < 400; i++) begin
      supply_fail_i  = ($urandom % 10) == 0;
      thermal_trip_i = ($urandom % 10) == 0;
      rstctl_wr_i    = ($urandom % 7) == 0;
      reg_wr_i       = ($urandom % 3) == 0;
      reg_wdata_i    = 8'($urandom);
      pwr_return_i   = ($urandom % 4) == 0;
      last_state_i   = 2'($urandom);
      step();
      cmp_all("R2-9 random");
    end

    // R1: reset clears even the sticky flag
    idle(); supply_fail_i = 1; step(); idle();
    do_reset();
    check("R1 reset clears all", {8'h00, reg_rdata_o}, 16'h0000);
    rst_aon_n = 1;
    repeat (3) @(negedge clk_aon);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule